// File: doc/BRIEF.md
# Shared-Wire Device Selection Controller

This block is the power and selection state machine of one device among several identical devices that share a single half-duplex wire. A line decoder outside the block turns wire activity into tokens: wake, command, transmit, sleep, and pause. A pause token may carry a 4-bit address. The controller keeps the device asleep, active or paused. It asks the line driver to send a response byte when a transmit token calls for one. It pulses a start strobe to the compute engine when a command is accepted.

The host selects one device at a time. It wakes all devices, then pauses every device except the one it wants to use. A pause token that carries an address pauses only the device whose strapped address matches. A pause token with no address pauses every awake device. A watchdog sends each device back to sleep a fixed number of cycles after its wake, and this holds whether the device is active or paused. The next wake token then restarts selection on every device.

Tokens enter on a valid/ready interface. The response byte leaves on a valid/ready interface. The wire is half duplex, so the device cannot listen while it has a response to send. `tok_ready` therefore stays low while a response waits, and a token offered during that time is not consumed. A response holds `resp_valid` and `resp_data` steady until `resp_ready` is high on a clock edge. The one exception is a fall into sleep, which drops a waiting response.

Top module: `wsc_select_ctrl`

## Requirements
- R1: Reset leaves `dev_state` at 0 (sleep), with `resp_valid` and `cmd_start` low and `tok_ready` high. The state codes are 0 for sleep, 1 for active and 2 for paused.
- R2: Token codes on `tok_kind` are 1 wake, 2 command, 3 transmit, 4 sleep and 5 pause. Other codes are ignored. A wake accepted in sleep makes `dev_state` 1 from the next cycle. Every other token accepted in sleep leaves the device asleep with no output.
- R3: A pause accepted while active makes `dev_state` 2 from the next cycle in two cases: `tok_has_addr` is low, or `tok_addr` equals `dev_addr`. A pause whose address does not match leaves the device active, and the device still acts on later tokens.
- R4: While paused, every token is ignored, wake included. `dev_state` stays 2, no response is raised and `cmd_start` stays low until the watchdog puts the device to sleep.
- R5: The first transmit accepted after a wake raises a response with byte 0x11. This happens even when the engine is busy.
- R6: A later transmit accepted while `eng_busy` is high raises no response.
- R7: A later transmit accepted while `eng_busy` is low raises a response carrying `eng_byte`. That byte is the error code when the command failed its format check, and the result otherwise.
- R8: A sleep token accepted while active makes `dev_state` 0 from the next cycle. A response still waiting when the device falls asleep is dropped.
- R9: After an accepted wake, the device stays awake for exactly WD_CYCLES cycles, whether it is active or paused. It then goes to sleep. The watchdog takes precedence over any token in that last cycle.
- R10: While `resp_valid` is high and `resp_ready` is low, `resp_data` holds and `tok_ready` is low. A response is consumed on a clock edge where `resp_valid` and `resp_ready` are both high.
- R11: A command accepted while active and not busy gives a `cmd_start` pulse of one cycle in the next cycle. A command accepted while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_valid | input | 1 | A decoded token is offered |
| tok_ready | output | 1 | A token can be taken (no response waiting) |
| tok_kind | input | 3 | Token code (see R2) |
| tok_has_addr | input | 1 | The pause token carries an address |
| tok_addr | input | ADDR_W | Address carried by a pause token |
| dev_addr | input | ADDR_W | Strapped address of this device |
| eng_busy | input | 1 | The compute engine is running |
| eng_byte | input | DATA_W | Error code or result byte from the engine |
| dev_state | output | 2 | 0 sleep, 1 active, 2 paused |
| resp_valid | output | 1 | A response byte waits to be sent |
| resp_ready | input | 1 | The line driver takes the response |
| resp_data | output | DATA_W | Response byte |
| cmd_start | output | 1 | One-cycle pulse that starts the engine |

## Verification
The bench goes after the following corner cases:
- **Sync byte after wake.** The first transmit after a wake must return 0x11 even when the engine is busy. A design that tested busy first would stay silent.
- **Pause addressing.** Pause tokens with a matching address, a mismatching address and no address are all sent. A design that compared addresses the wrong way, or ignored the no-address case, would park the wrong device.
- **Paused state.** Every token type is offered to a paused device. A leaky design would answer or start the engine.
- **Watchdog length.** The awake cycles are counted, so an off-by-one counter shows up.
- **Back-pressure.** The bench stalls a response, then lets the watchdog expire over it. This exposes a design that changes data, takes tokens while talking, or keeps a stale response through sleep.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP  = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_PAUSED = 2'd2
  } dev_state_e;

  typedef enum logic [2:0] {
    TK_NONE  = 3'd0,
    TK_WAKE  = 3'd1,
    TK_CMD   = 3'd2,
    TK_XMIT  = 3'd3,
    TK_SLEEP = 3'd4,
    TK_PAUSE = 3'd5
  } tok_kind_e;

endpackage

// File: rtl/wsc_watchdog.sv
// Down-counter reloaded on wake; flags the last awake cycle.
module wsc_watchdog #(
  parameter int WD_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expire
);
  localparam int WD_W = $clog2(WD_CYCLES + 1);

  logic [WD_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= WD_W'(WD_CYCLES);
    end else if (run && cnt != '0) begin
      cnt <= cnt - WD_W'(1);
    end
  end

  assign expire = run && (cnt == WD_W'(1));
endmodule

// File: rtl/wsc_addr_match.sv
// A pause without an address selects every device.
module wsc_addr_match #(
  parameter int ADDR_W = 4
) (
  input  logic              has_addr,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic              hit
);
  assign hit = !has_addr || (tok_addr == dev_addr);
endmodule

// File: rtl/wsc_resp_reg.sv
// One-entry response holder with valid/ready output and a flush.
module wsc_resp_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              flush,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (flush) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wsc_select_ctrl.sv
module wsc_select_ctrl
  import wsc_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter int          DATA_W    = 8,
  parameter int          WD_CYCLES = 200,
  parameter logic [7:0]  SYNC_BYTE = 8'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  output logic              tok_ready,
  input  logic [2:0]        tok_kind,
  input  logic              tok_has_addr,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              eng_busy,
  input  logic [DATA_W-1:0] eng_byte,
  output logic [1:0]        dev_state,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [DATA_W-1:0] resp_data,
  output logic              cmd_start
);
  localparam logic [DATA_W-1:0] SYNC_W = DATA_W'(SYNC_BYTE);

  dev_state_e        state_q, state_d;
  logic              sync_q, sync_d;
  logic              cmd_d;
  logic              accept, expire, addr_hit;
  logic              wd_load, resp_load, resp_flush;
  logic [DATA_W-1:0] resp_byte;
  tok_kind_e         kind;

  assign kind   = tok_kind_e'(tok_kind);
  assign accept = tok_valid && tok_ready;

  wsc_watchdog #(.WD_CYCLES(WD_CYCLES)) u_wd (
    .clk(clk), .rst_n(rst_n), .load(wd_load),
    .run(state_q != ST_SLEEP), .expire(expire)
  );

  wsc_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .has_addr(tok_has_addr), .tok_addr(tok_addr),
    .dev_addr(dev_addr), .hit(addr_hit)
  );

  wsc_resp_reg #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .load(resp_load), .load_data(resp_byte),
    .flush(resp_flush), .ready(resp_ready),
    .valid(resp_valid), .data(resp_data)
  );

  // Half duplex: no listening while a response waits on the wire.
  assign tok_ready = !resp_valid;

  always_comb begin
    state_d    = state_q;
    sync_d     = sync_q;
    cmd_d      = 1'b0;
    wd_load    = 1'b0;
    resp_load  = 1'b0;
    resp_byte  = eng_byte;
    resp_flush = 1'b0;
    if (expire) begin
      state_d    = ST_SLEEP;
      resp_flush = 1'b1;
    end else begin
      unique case (state_q)
        ST_SLEEP: begin
          if (accept && kind == TK_WAKE) begin
            state_d = ST_ACTIVE;
            sync_d  = 1'b1;
            wd_load = 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (accept) begin
            case (kind)
              TK_SLEEP: begin
                state_d    = ST_SLEEP;
                resp_flush = 1'b1;
              end
              TK_PAUSE: if (addr_hit) state_d = ST_PAUSED;
              TK_CMD:   cmd_d = !eng_busy;
              TK_XMIT: begin
                if (sync_q) begin
                  resp_load = 1'b1;
                  resp_byte = SYNC_W;
                  sync_d    = 1'b0;
                end else if (!eng_busy) begin
                  resp_load = 1'b1;
                end
              end
              default: ;
            endcase
          end
        end
        ST_PAUSED: ;
        default: state_d = ST_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_SLEEP;
      sync_q    <= 1'b0;
      cmd_start <= 1'b0;
    end else begin
      state_q   <= state_d;
      sync_q    <= sync_d;
      cmd_start <= cmd_d;
    end
  end

  assign dev_state = state_q;
endmodule

// File: rtl/wsc_select_checker.sv
module wsc_select_checker #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int WD_CYCLES = 200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tok_valid,
  input logic [2:0]        tok_kind,
  input logic [1:0]        dev_state,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic [DATA_W-1:0] resp_data,
  input logic              cmd_start
);
  localparam int CW = $clog2(WD_CYCLES + 2);
  logic [CW-1:0] awake_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                awake_cnt <= '0;
    else if (dev_state == 2'd0) awake_cnt <= '0;
    else                       awake_cnt <= awake_cnt + CW'(1);
  end

  assert_wake_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_state == 2'd0 && !(tok_valid && tok_kind == 3'd1)) |=> dev_state == 2'd0);

  assert_paused_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_state == 2'd2) |=> (!cmd_start && !$rose(resp_valid)));

  assert_asleep_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_state == 2'd0) |-> !resp_valid);

  assert_paused_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_state == 2'd2) |=> (dev_state == 2'd2 || dev_state == 2'd0));

  assert_wd_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_state != 2'd0) |-> (awake_cnt < CW'(WD_CYCLES)));

  assert_resp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=>
      ((resp_valid && $stable(resp_data)) || (!resp_valid && dev_state == 2'd0)));

  assert_cmd_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);
endmodule

bind wsc_select_ctrl wsc_select_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WD_CYCLES(WD_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
  .dev_state(dev_state), .resp_valid(resp_valid), .resp_ready(resp_ready),
  .resp_data(resp_data), .cmd_start(cmd_start)
);

// File: tb/tb_wsc_select_ctrl.sv
`timescale 1ns/1ps
module tb_wsc_select_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WD = 60;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tok_valid = 1'b0;
  logic       tok_ready;
  logic [2:0] tok_kind = 3'd0;
  logic       tok_has_addr = 1'b0;
  logic [3:0] tok_addr = 4'd0;
  logic [3:0] dev_addr = 4'd9;
  logic       eng_busy = 1'b0;
  logic [7:0] eng_byte = 8'h00;
  logic [1:0] dev_state;
  logic       resp_valid;
  logic       resp_ready = 1'b1;
  logic [7:0] resp_data;
  logic       cmd_start;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_state = 0, m_wd = 0, m_rd = 0;
  bit m_sync = 0, m_rv = 0, m_cs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wsc_select_ctrl #(.WD_CYCLES(WD)) dut (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
    .tok_kind(tok_kind), .tok_has_addr(tok_has_addr), .tok_addr(tok_addr),
    .dev_addr(dev_addr), .eng_busy(eng_busy), .eng_byte(eng_byte),
    .dev_state(dev_state), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_data(resp_data), .cmd_start(cmd_start)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_wd = 0; m_sync = 0; m_rv = 0; m_rd = 0; m_cs = 0;
    end else begin
      bit acc, ex, ld;
      acc = tok_valid && !m_rv;
      ex  = (m_state != 0) && (m_wd == 1);
      ld  = 0;
      m_cs = 0;
      if (m_rv && resp_ready) m_rv = 0;
      if (ex) begin
        m_state = 0; m_rv = 0;
      end else if (acc) begin
        if (m_state == 0 && tok_kind == 3'd1) begin
          m_state = 1; m_sync = 1; ld = 1;
        end else if (m_state == 1) begin
          case (tok_kind)
            3'd4: begin m_state = 0; m_rv = 0; end
            3'd5: if (!tok_has_addr || tok_addr == dev_addr) m_state = 2;
            3'd2: m_cs = !eng_busy;
            3'd3: if (m_sync) begin m_rv = 1; m_rd = 'h11; m_sync = 0; end
                  else if (!eng_busy) begin m_rv = 1; m_rd = eng_byte; end
            default: ;
          endcase
        end
      end
      if (ld) m_wd = WD;
      else if (m_state != 0 && m_wd != 0) m_wd = m_wd - 1;
      else if (ex) m_wd = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 state vs model", dev_state, m_state);
      chk("R10 resp_valid vs model", resp_valid, m_rv);
      if (m_rv) chk("R7 resp_data vs model", resp_data, m_rd);
      chk("R11 cmd_start vs model", cmd_start, m_cs);
      chk("R10 tok_ready vs model", tok_ready, !m_rv);
    end
  end

  task automatic send(input int kind, input bit has, input int addr);
    tok_valid = 1; tok_kind = 3'(kind); tok_has_addr = has; tok_addr = 4'(addr);
    @(negedge clk);
    tok_valid = 0; tok_kind = 0; tok_has_addr = 0;
  endtask

  task automatic wait_sleep();
    for (int i = 0; i < 2*WD && dev_state != 2'd0; i++) @(negedge clk);
  endtask

  initial begin
    int n;
    #(CLK_PERIOD*20000);
    errors++;
    $display("FAIL watchdog: run hung actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset state", dev_state, 0);
    chk("R1 reset resp_valid", resp_valid, 0);
    chk("R1 reset cmd_start", cmd_start, 0);
    chk("R1 reset tok_ready", tok_ready, 1);
    rst_n = 1;
    @(negedge clk);
    // R2: non-wake tokens in sleep do nothing
    send(3, 0, 0); send(2, 0, 0); send(5, 0, 0); send(4, 0, 0); send(7, 0, 0);
    chk("R2 asleep after stray tokens", dev_state, 0);
    chk("R2 no response asleep", resp_valid, 0);
    send(1, 0, 0);
    chk("R2 wake to active", dev_state, 1);
    // R5: sync byte even when busy, held under back-pressure (R10)
    eng_busy = 1; resp_ready = 0;
    send(3, 0, 0);
    chk("R5 sync response raised", resp_valid, 1);
    chk("R5 sync byte", resp_data, 'h11);
    send(2, 0, 0);
    repeat (2) @(negedge clk);
    chk("R10 data held", resp_data, 'h11);
    chk("R10 tok_ready low", tok_ready, 0);
    resp_ready = 1;
    @(negedge clk);
    chk("R10 consumed", resp_valid, 0);
    // R6 busy transmit ignored, R11 busy command ignored
    send(3, 0, 0);
    chk("R6 busy transmit silent", resp_valid, 0);
    send(2, 0, 0);
    chk("R11 busy command ignored", cmd_start, 0);
    eng_busy = 0; eng_byte = 8'hE3;
    send(2, 0, 0);
    chk("R11 command pulse", cmd_start, 1);
    @(negedge clk);
    chk("R11 pulse one cycle", cmd_start, 0);
    send(3, 0, 0);
    chk("R7 error byte", resp_data, 'hE3);
    chk("R7 response raised", resp_valid, 1);
    @(negedge clk);
    // R3 mismatch then match
    send(5, 1, 3);
    chk("R3 mismatch stays active", dev_state, 1);
    eng_byte = 8'h5A;
    send(3, 0, 0);
    chk("R3 still answers after mismatch", resp_data, 'h5A);
    @(negedge clk);
    send(5, 1, 9);
    chk("R3 match pauses", dev_state, 2);
    // R4 paused ignores all
    send(3, 0, 0); send(2, 0, 0); send(4, 0, 0); send(1, 0, 0);
    chk("R4 paused holds", dev_state, 2);
    chk("R4 no response", resp_valid, 0);
    chk("R4 no command", cmd_start, 0);
    wait_sleep();
    chk("R9 paused falls asleep", dev_state, 0);
    // R9 exact awake length
    send(1, 0, 0);
    n = 0;
    while (dev_state != 2'd0 && n < 2*WD) begin n++; @(negedge clk); end
    chk("R9 awake cycles", n, WD);
    // R3 pause without address
    send(1, 0, 0);
    send(5, 0, 0);
    chk("R3 addressless pause", dev_state, 2);
    wait_sleep();
    // R8 sleep token
    send(1, 0, 0);
    send(4, 0, 0);
    chk("R8 sleep token", dev_state, 0);
    // R8 pending response dropped by watchdog
    send(1, 0, 0);
    resp_ready = 0;
    send(3, 0, 0);
    chk("R8 pending before expiry", resp_valid, 1);
    wait_sleep();
    chk("R8 response dropped", resp_valid, 0);
    chk("R8 ready again", tok_ready, 1);
    resp_ready = 1;
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule